// File: doc/BRIEF.md
# Retriggerable Edge-Triggered One-Shot Timer

This block produces a single high pulse of a programmed number of clock cycles each time a qualifying edge shows up on one of its two trigger pins. The rise pin fires on a low-to-high change, but only while the fall pin sits high. The fall pin fires on a high-to-low change, but only while the rise pin sits low. Each trigger pin therefore enables or blocks the other. Both pins are asynchronous to the clock and pass through a two-flop synchronizer before edge detection.

A per-channel active-low clear overrides everything. While it is low, the output is forced low at once, with no wait for a clock edge, and any running pulse is cancelled. A per-channel mode bit picks one of two behaviours. In retriggerable mode each new trigger restarts the pulse, so the pulse ends one full period after the last trigger. In one-shot mode triggers that arrive during a pulse are ignored. The pulse length is a 16-bit input per channel, and a length of zero produces no pulse. The number of independent channels is a parameter, two by default.

Top module: `retrig_oneshot`

## Requirements
- R1: While a channel's clear input is 0, its q output is 0 and its q_n output is 1 in the same cycle, whatever the trigger pins do, and any running pulse is cancelled.
- R2: A 0-to-1 change on trig_rise while trig_fall is 1 starts a pulse. q goes high on the third rising clock edge after the input change and stays high for exactly PERIOD clock cycles.
- R3: A 1-to-0 change on trig_fall while trig_rise is 0 starts a pulse with the same latency and length as R2.
- R4: A rising change on trig_rise while trig_fall is 0 starts no pulse, and neither does a falling change on trig_fall while trig_rise is 1. A falling change on trig_rise or a rising change on trig_fall never starts a pulse.
- R5: q_n is always the complement of q.
- R6: With retrig_en=1, a qualifying trigger during a pulse reloads the count, so q stays high until PERIOD cycles after the last accepted trigger.
- R7: With retrig_en=0, qualifying triggers during a pulse are ignored and the pulse lasts PERIOD cycles from the first trigger.
- R8: After the synchronous reset rst_n, every channel is idle with q=0 and q_n=1.
- R9: Channels are independent. Clearing or triggering one channel has no effect on another channel's output.
- R10: A PERIOD of 0 suppresses the pulse. Releasing the clear does not start a pulse by itself.
- R11: A trigger whose edge is detected while clear is low, or in the first clock cycle after clear goes high, is ignored. One detected a cycle later is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_n | input | NCH | Per-channel active-low clear |
| trig_rise | input | NCH | Trigger pin that fires on a rising change, enabled when trig_fall is high |
| trig_fall | input | NCH | Trigger pin that fires on a falling change, enabled when trig_rise is low |
| retrig_en | input | NCH | 1 = retriggerable mode, 0 = one-shot mode |
| period | input | NCH*CW | Pulse length in cycles; channel i uses bits [i*CW +: CW] |
| q | output | NCH | Pulse output |
| q_n | output | NCH | Complement of q |

## Verification
On every cycle the assertions check four things. q_n is the complement of q. A sampled clear leaves q low on the following edge. A pulse only ever starts from a non-zero period. A pulse only starts after clear has been high for two sampled edges. The bench's scenarios cover the rest. They show the three-edge start latency, the exact pulse lengths and which pin-level combinations enable or block a trigger. They also show how retriggerable and one-shot modes differ on the same trigger train. Finally, they show the one-cycle boundary on each side of clear release and that the channels stay isolated.

// File: rtl/retrig_oneshot_pkg.sv
// Shared types for the one-shot timer.
package retrig_oneshot_pkg;
    // Channel behaviour when a trigger arrives during a pulse.
    typedef enum logic {
        MODE_ONESHOT = 1'b0,
        MODE_RETRIG  = 1'b1
    } trig_mode_e;
endpackage

// File: rtl/os_sync2.sv
// Two-flop synchronizer for asynchronous level inputs.
// Assumes: rst_n is synchronous; RST_VAL is the idle level of the input.
module os_sync2 #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic meta;

    // Shift the input through two flops to settle metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/os_edge_qual.sv
// Detects a qualified edge on the synchronized trigger pins.
// Fires for one cycle on a rise of rs while fs is high, or a fall of fs while rs is low.
// Assumes: inputs are already synchronous to clk.
module os_edge_qual (
    input  logic clk,
    input  logic rst_n,
    input  logic rs,
    input  logic fs,
    output logic fire
);
    logic rs_d, fs_d;
    logic rise_hit, fall_hit;

    // Hold the previous sample of each pin for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rs_d <= 1'b0;
            fs_d <= 1'b1;
        end else begin
            rs_d <= rs;
            fs_d <= fs;
        end
    end

    // Combine each edge with the enabling level of the other pin.
    always_comb begin
        rise_hit = rs & ~rs_d & fs;
        fall_hit = ~fs & fs_d & ~rs;
        fire     = rise_hit | fall_hit;
    end
endmodule

// File: rtl/os_pulse_timer.sv
// Down-counter that holds the pulse length; a non-zero count means the pulse is active.
// Loads PERIOD on an accepted trigger, clears on clr_n low.
// Assumes: fire is a one-cycle strobe; a trigger in the first cycle after clear release is dropped.
module os_pulse_timer
    import retrig_oneshot_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_n,
    input  logic          fire,
    input  trig_mode_e    mode,
    input  logic [CW-1:0] period,
    output logic          active
);
    logic [CW-1:0] cnt;
    logic          clr_q;
    logic          idle;
    logic          load;

    // Decide whether this cycle's trigger is accepted.
    always_comb begin
        idle   = (cnt == '0);
        load   = fire && clr_n && clr_q && (period != '0) &&
                 ((mode == MODE_RETRIG) || idle);
        active = !idle;
    end

    // Track clear history and step the counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            clr_q <= 1'b0;
        end else begin
            clr_q <= clr_n;
            if (!clr_n) begin
                cnt <= '0;
            end else if (load) begin
                cnt <= period;
            end else if (!idle) begin
                cnt <= cnt - CW'(1);
            end
        end
    end
endmodule

// File: rtl/os_channel.sv
// One timer channel: synchronizers, edge qualifier, counter and output masking.
// Assumes: clr_n masks the output at once, without waiting for a clock edge.
module os_channel
    import retrig_oneshot_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_n,
    input  logic          trig_rise,
    input  logic          trig_fall,
    input  logic          retrig_en,
    input  logic [CW-1:0] period,
    output logic          q,
    output logic          q_n
);
    logic rs, fs, fire, active;
    trig_mode_e mode;

    os_sync2 #(.RST_VAL(1'b0)) u_sync_r (.clk(clk), .rst_n(rst_n), .d(trig_rise), .q(rs));
    os_sync2 #(.RST_VAL(1'b1)) u_sync_f (.clk(clk), .rst_n(rst_n), .d(trig_fall), .q(fs));

    os_edge_qual u_edge (.clk(clk), .rst_n(rst_n), .rs(rs), .fs(fs), .fire(fire));

    os_pulse_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .fire(fire),
        .mode(mode), .period(period), .active(active)
    );

    // Map the mode bit and gate the outputs with the clear.
    always_comb begin
        mode = trig_mode_e'(retrig_en);
        q    = active & clr_n;
        q_n  = ~q;
    end
endmodule

// File: rtl/retrig_oneshot.sv
// Top: NCH independent retriggerable one-shot channels.
// Assumes: channel i takes its length from period[i*CW +: CW].
module retrig_oneshot #(
    parameter int NCH = 2,
    parameter int CW  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   clr_n,
    input  logic [NCH-1:0]   trig_rise,
    input  logic [NCH-1:0]   trig_fall,
    input  logic [NCH-1:0]   retrig_en,
    input  logic [NCH*CW-1:0] period,
    output logic [NCH-1:0]   q,
    output logic [NCH-1:0]   q_n
);
    // One channel instance per index.
    for (genvar i = 0; i < NCH; i++) begin : g_ch
        os_channel #(.CW(CW)) u_ch (
            .clk(clk), .rst_n(rst_n), .clr_n(clr_n[i]),
            .trig_rise(trig_rise[i]), .trig_fall(trig_fall[i]),
            .retrig_en(retrig_en[i]), .period(period[i*CW +: CW]),
            .q(q[i]), .q_n(q_n[i])
        );
    end
endmodule

// File: rtl/retrig_oneshot_chk.sv
// Property checker for retrig_oneshot, attached by bind.
module retrig_oneshot_chk #(
    parameter int NCH = 2,
    parameter int CW  = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NCH-1:0]   clr_n,
    input logic [NCH*CW-1:0] period,
    input logic [NCH-1:0]   q,
    input logic [NCH-1:0]   q_n
);
    for (genvar i = 0; i < NCH; i++) begin : g_chk
        // R5
        comp_chk: assert property (@(posedge clk) disable iff (!rst_n)
            q_n[i] == !q[i]);
        // R1
        clr_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !clr_n[i] |=> !q[i]);
        // R10
        zero_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(q[i]) |-> ($past(period[i*CW +: CW]) != '0));
        // R11
        release_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(q[i]) |-> ($past(clr_n[i]) && $past(clr_n[i], 2)));
    end
endmodule

bind retrig_oneshot retrig_oneshot_chk #(.NCH(NCH), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .period(period), .q(q), .q_n(q_n)
);

// File: tb/tb_retrig_oneshot.sv
module tb_retrig_oneshot;
    localparam int NCH = 2;
    localparam int CW  = 16;

    logic clk = 1'b0;
    logic rst_n;
    logic [NCH-1:0] clr_n, trig_rise, trig_fall, retrig_en, q, q_n;
    logic [NCH*CW-1:0] period;

    int checks = 0;
    int errors = 0;
    int hi0 = 0;
    int hi1 = 0;

    retrig_oneshot #(.NCH(NCH), .CW(CW)) dut (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .trig_rise(trig_rise),
        .trig_fall(trig_fall), .retrig_en(retrig_en), .period(period),
        .q(q), .q_n(q_n)
    );

    always #10 clk = ~clk;

    // Count high cycles per channel (value held before each edge).
    always @(posedge clk) begin
        if (q[0]) hi0 <= hi0 + 1;
        if (q[1]) hi1 <= hi1 + 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clr_counts();
        @(negedge clk);
        hi0 = 0;
        hi1 = 0;
    endtask

    task automatic set_period(input int ch, input int p);
        period[ch*CW +: CW] = CW'(p);
    endtask

    task automatic t_reset();
        check(q == '0, "R8 q after reset", int'(q), 0);
        check(q_n == '1, "R8/R5 q_n after reset", int'(q_n), 3);
    endtask

    task automatic t_rise();
        set_period(0, 5);
        clr_counts();
        trig_rise[0] = 1'b1;
        wait_n(2);
        check(q[0] == 1'b0, "R2 q before third edge", int'(q[0]), 0);
        wait_n(1);
        check(q[0] == 1'b1, "R2 q at third edge", int'(q[0]), 1);
        check(q_n[0] == 1'b0, "R5 q_n during pulse", int'(q_n[0]), 0);
        wait_n(10);
        trig_rise[0] = 1'b0;
        wait_n(5);
        check(hi0 == 5, "R2 pulse width", hi0, 5);
        check(q_n[0] == 1'b1, "R5 q_n after pulse", int'(q_n[0]), 1);
    endtask

    task automatic t_fall();
        set_period(0, 6);
        clr_counts();
        trig_fall[0] = 1'b0;
        wait_n(12);
        trig_fall[0] = 1'b1;
        wait_n(6);
        check(hi0 == 6, "R3 fall-pin pulse width", hi0, 6);
    endtask

    task automatic t_gate();
        clr_n[0] = 1'b0;
        trig_rise[0] = 1'b1;
        wait_n(2);
        trig_fall[0] = 1'b0;
        wait_n(5);
        clr_n[0] = 1'b1;
        wait_n(4);
        clr_counts();
        trig_rise[0] = 1'b0;
        wait_n(5);
        trig_rise[0] = 1'b1;
        wait_n(5);
        trig_fall[0] = 1'b1;
        wait_n(5);
        trig_fall[0] = 1'b0;
        wait_n(5);
        trig_rise[0] = 1'b0;
        wait_n(5);
        trig_fall[0] = 1'b1;
        wait_n(8);
        check(hi0 == 0, "R4 blocked edges start nothing", hi0, 0);
    endtask

    task automatic train(input int ch, input int p, input bit mode, input int exp, input string req);
        retrig_en[ch] = mode;
        set_period(ch, p);
        clr_counts();
        trig_rise[ch] = 1'b1;
        wait_n(2);
        trig_rise[ch] = 1'b0;
        wait_n(2);
        trig_rise[ch] = 1'b1;
        wait_n(2);
        trig_rise[ch] = 1'b0;
        wait_n(p + 8);
        check((ch == 0 ? hi0 : hi1) == exp, req, (ch == 0 ? hi0 : hi1), exp);
    endtask

    task automatic t_clear();
        retrig_en[0] = 1'b0;
        set_period(0, 20);
        clr_counts();
        trig_rise[0] = 1'b1;
        wait_n(6);
        check(q[0] == 1'b1, "R1 pulse running before clear", int'(q[0]), 1);
        clr_n[0] = 1'b0;
        #1;
        check(q[0] == 1'b0 && q_n[0] == 1'b1, "R1 clear forces q low at once", int'(q[0]), 0);
        trig_rise[0] = 1'b0;
        wait_n(3);
        trig_rise[0] = 1'b1;
        wait_n(5);
        check(q[0] == 1'b0, "R1 triggers ignored under clear", int'(q[0]), 0);
        clr_counts();
        clr_n[0] = 1'b1;
        wait_n(25);
        check(hi0 == 0, "R10 release starts no pulse", hi0, 0);
        trig_rise[0] = 1'b0;
        wait_n(3);
    endtask

    task automatic t_zero();
        set_period(0, 0);
        clr_counts();
        trig_rise[0] = 1'b1;
        wait_n(5);
        trig_rise[0] = 1'b0;
        wait_n(5);
        check(hi0 == 0, "R10 zero period no pulse", hi0, 0);
    endtask

    task automatic t_release();
        set_period(0, 4);
        clr_n[0] = 1'b0;
        wait_n(3);
        clr_counts();
        trig_rise[0] = 1'b1;
        wait_n(2);
        clr_n[0] = 1'b1;
        wait_n(10);
        check(hi0 == 0, "R11 edge on release cycle ignored", hi0, 0);
        trig_rise[0] = 1'b0;
        clr_n[0] = 1'b0;
        wait_n(5);
        clr_counts();
        trig_rise[0] = 1'b1;
        wait_n(1);
        clr_n[0] = 1'b1;
        wait_n(10);
        check(hi0 == 4, "R11 edge one cycle later accepted", hi0, 4);
        trig_rise[0] = 1'b0;
        wait_n(3);
    endtask

    task automatic t_indep();
        set_period(0, 5);
        set_period(1, 7);
        retrig_en = '0;
        clr_n[0] = 1'b0;
        clr_counts();
        trig_rise = 2'b11;
        wait_n(14);
        check(hi1 == 7, "R9 channel 1 runs while channel 0 cleared", hi1, 7);
        check(hi0 == 0, "R9 channel 0 stays cleared", hi0, 0);
        trig_rise = 2'b00;
        clr_n = 2'b01;
        wait_n(4);
        clr_counts();
        trig_rise[0] = 1'b1;
        wait_n(12);
        check(hi0 == 5, "R9 channel 0 runs while channel 1 cleared", hi0, 5);
        check(hi1 == 0, "R9 channel 1 untouched", hi1, 0);
        trig_rise = 2'b00;
        clr_n = 2'b11;
        wait_n(3);
    endtask

    initial begin
        rst_n = 1'b0;
        clr_n = '1;
        trig_rise = '0;
        trig_fall = '1;
        retrig_en = '0;
        period = '0;
        wait_n(4);
        t_reset();
        rst_n = 1'b1;
        wait_n(2);
        t_reset();
        t_rise();
        t_fall();
        t_gate();
        train(0, 8, 1'b1, 12, "R6 retrigger extends pulse");
        train(1, 8, 1'b0, 8, "R7 one-shot ignores retrigger");
        t_clear();
        t_zero();
        t_release();
        t_indep();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule